// File: doc/BRIEF.md
# Indexed/Direct Pixel Selector

This block is the per-pixel colour stage behind a frame buffer that holds three planes at the same pixel position: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. A stream of pixel triples enters, one per cycle while `in_valid` is high. The top byte of the control word is a tag. When the tag is 0x03, the pixel takes its colour from the direct word, which stores the colour bytes in blue-green-red order. Any other tag makes the pixel a palette pixel: its index goes out on a palette read port, and the external table returns the red, green and blue bytes one cycle later.

The stream walks a fixed raster. Every line has `STRIDE` positions, whatever the visible width is, and every frame has `MAX_ROWS` lines. The block keeps its own column and row position, advancing it once per accepted pixel. Pixels that fall outside the visible window set by `cfg_width` and `cfg_height` are consumed but produce no output. Visible pixels leave as 24-bit RGB with `out_valid`, exactly one cycle after they enter, in order and with no gaps while the input is continuous.

Top module: `pixel_select`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is low. The first pixel accepted after reset sits at column 0, row 0.
- R2: A pixel whose control word has bits 31:24 equal to 0x03 is a direct pixel. Its output has red = direct[7:0], green = direct[15:8] and blue = direct[23:16]. `out_rgb` always carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: A pixel with any other tag value is a palette pixel. In the cycle the pixel is presented, `pal_rd_en` is high and `pal_addr` equals `in_index`. The output is the `pal_rgb` word that the table returns in the following cycle, with red in 23:16, green in 15:8 and blue in 7:0.
- R4: Control bits 23:0 and direct-word bits 31:24 have no effect on the output. For a direct pixel, the index has no effect on the output.
- R5: A visible pixel accepted at a clock edge appears on `out_valid`/`out_rgb` after that edge, until the next edge. Output order equals input order, and back-to-back visible input gives back-to-back output.
- R6: The column advances by one per accepted pixel and wraps to 0 after column `STRIDE`-1. A pixel whose column is not below `cfg_width` gives no output.
- R7: The row advances when the column wraps and returns to 0 after row `MAX_ROWS`-1. A pixel whose row is not below `cfg_height` gives no output.
- R8: A cycle with `in_valid` low leaves the position unchanged and gives `out_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | $clog2(STRIDE+1) | Visible columns per line |
| cfg_height | input | $clog2(MAX_ROWS+1) | Visible lines per frame |
| in_valid | input | 1 | Pixel triple present this cycle |
| in_index | input | 8 | Palette index plane byte |
| in_direct | input | 32 | Direct-colour word, blue-green-red in bits 23:0 |
| in_ctrl | input | 32 | Control word, tag in bits 31:24 |
| pal_rd_en | output | 1 | Palette read request |
| pal_addr | output | 8 | Palette read address |
| pal_rgb | input | 24 | Palette entry returned one cycle after the request |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Output colour, red 23:16, green 15:8, blue 7:0 |

## Verification
Two things can happen in the same cycle here. The colour source can change from one pixel to the next, and the pixel can cross the edge of the visible window or of a line. The bench runs a continuous stream in which every tag value occurs and direct and palette pixels alternate. Some of these mode changes fall on the last visible column, on a column wrap or on the frame wrap. Each output cycle is compared against a colour and a visibility computed in the bench from its own palette formula and its own raster counters. Idle gaps and a reset in the middle of a stream test that the position holds and then restarts correctly.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

    localparam logic [7:0] DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    typedef enum logic {
        SRC_PALETTE = 1'b0,
        SRC_DIRECT  = 1'b1
    } colour_src_e;

    typedef struct packed {
        logic        valid;
        colour_src_e src;
        rgb_t        direct;
    } stage_t;

    function automatic colour_src_e src_of_ctrl(input logic [31:0] ctrl);
        return (ctrl[31:24] == DIRECT_TAG) ? SRC_DIRECT : SRC_PALETTE;
    endfunction

    function automatic rgb_t unpack_bgr(input logic [31:0] word);
        rgb_t c;
        c.red   = word[7:0];
        c.green = word[15:8];
        c.blue  = word[23:16];
        return c;
    endfunction

endpackage

// File: rtl/raster_pos.sv
module raster_pos #(
    parameter int STRIDE   = 1024,
    parameter int MAX_ROWS = 768,
    localparam int COL_W   = $clog2(STRIDE),
    localparam int ROW_W   = $clog2(MAX_ROWS),
    localparam int WCFG_W  = $clog2(STRIDE + 1),
    localparam int HCFG_W  = $clog2(MAX_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [WCFG_W-1:0] cfg_width,
    input  logic [HCFG_W-1:0] cfg_height,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row,
    output logic              visible
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(STRIDE - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(MAX_ROWS - 1);

    logic [WCFG_W-1:0] col_ext;
    logic [HCFG_W-1:0] row_ext;

    assign col_ext = WCFG_W'(col);
    assign row_ext = HCFG_W'(row);
    assign visible = (col_ext < cfg_width) && (row_ext < cfg_height);

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (col == LAST_COL) begin
                col <= '0;
                row <= (row == LAST_ROW) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pixel_stage.sv
module pixel_stage
    import pixsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic [31:0] direct_word,
    input  logic [31:0] ctrl_word,
    output stage_t      stage_q
);

    stage_t stage_d;

    always_comb begin
        stage_d.valid  = take;
        stage_d.src    = src_of_ctrl(ctrl_word);
        stage_d.direct = unpack_bgr(direct_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q.valid <= 1'b0;
        end else begin
            stage_q.valid <= stage_d.valid;
        end
        stage_q.src    <= stage_d.src;
        stage_q.direct <= stage_d.direct;
    end

endmodule

// File: rtl/colour_mux.sv
module colour_mux
    import pixsel_pkg::*;
(
    input  stage_t      stage_q,
    input  logic [23:0] pal_rgb,
    output logic        out_valid,
    output logic [23:0] out_rgb
);

    rgb_t chosen;

    always_comb begin
        if (stage_q.src == SRC_DIRECT) begin
            chosen = stage_q.direct;
        end else begin
            chosen = rgb_t'(pal_rgb);
        end
    end

    assign out_valid = stage_q.valid;
    assign out_rgb   = chosen;

endmodule

// File: rtl/pixel_select.sv
module pixel_select
    import pixsel_pkg::*;
#(
    parameter int STRIDE   = 1024,
    parameter int MAX_ROWS = 768,
    localparam int COL_W   = $clog2(STRIDE),
    localparam int ROW_W   = $clog2(MAX_ROWS),
    localparam int WCFG_W  = $clog2(STRIDE + 1),
    localparam int HCFG_W  = $clog2(MAX_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WCFG_W-1:0] cfg_width,
    input  logic [HCFG_W-1:0] cfg_height,
    input  logic              in_valid,
    input  logic [7:0]        in_index,
    input  logic [31:0]       in_direct,
    input  logic [31:0]       in_ctrl,
    output logic              pal_rd_en,
    output logic [7:0]        pal_addr,
    input  logic [23:0]       pal_rgb,
    output logic              out_valid,
    output logic [23:0]       out_rgb
);

    logic [COL_W-1:0] pos_col;
    logic [ROW_W-1:0] pos_row;
    logic             pos_visible;
    stage_t           stage_q;

    assign pal_rd_en = in_valid;
    assign pal_addr  = in_index;

    raster_pos #(
        .STRIDE  (STRIDE),
        .MAX_ROWS(MAX_ROWS)
    ) u_pos (
        .clk       (clk),
        .rst       (rst),
        .step      (in_valid),
        .cfg_width (cfg_width),
        .cfg_height(cfg_height),
        .col       (pos_col),
        .row       (pos_row),
        .visible   (pos_visible)
    );

    pixel_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .take       (in_valid && pos_visible),
        .direct_word(in_direct),
        .ctrl_word  (in_ctrl),
        .stage_q    (stage_q)
    );

    colour_mux u_mux (
        .stage_q  (stage_q),
        .pal_rgb  (pal_rgb),
        .out_valid(out_valid),
        .out_rgb  (out_rgb)
    );

endmodule

// File: rtl/pixsel_checker.sv
module pixsel_checker #(
    parameter int STRIDE   = 1024,
    parameter int MAX_ROWS = 768,
    localparam int COL_W   = $clog2(STRIDE),
    localparam int ROW_W   = $clog2(MAX_ROWS)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      in_direct,
    input logic [31:0]      in_ctrl,
    input logic [23:0]      pal_rgb,
    input logic             out_valid,
    input logic [23:0]      out_rgb,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row,
    input logic             visible
);

    // R1: the output is quiet in the cycle after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    // R5: every output pixel comes from an input one cycle earlier
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5: a visible pixel is never dropped
    a_r5_no_bubble: assert property (@(posedge clk) disable iff (rst)
        (in_valid && visible) |=> out_valid);

    // R2: byte order of a direct pixel
    a_r2_direct_bytes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && visible && in_ctrl[31:24] == 8'h03) |=>
        (out_rgb == {$past(in_direct[7:0]), $past(in_direct[15:8]), $past(in_direct[23:16])}));

    // R3: a palette pixel shows the returned table entry
    a_r3_palette_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && visible && in_ctrl[31:24] != 8'h03) |=> (out_rgb == pal_rgb));

    // R6: pixels outside the window give no output
    a_r6_hidden: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !visible) |=> !out_valid);

    // R6: the column wraps at the stride
    a_r6_col_wrap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && col == COL_W'(STRIDE - 1)) |=> (col == '0));

    // R8: idle cycles hold the position
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(col) && $stable(row)));

endmodule

bind pixel_select pixsel_checker #(
    .STRIDE  (STRIDE),
    .MAX_ROWS(MAX_ROWS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_direct(in_direct),
    .in_ctrl  (in_ctrl),
    .pal_rgb  (pal_rgb),
    .out_valid(out_valid),
    .out_rgb  (out_rgb),
    .col      (pos_col),
    .row      (pos_row),
    .visible  (pos_visible)
);

// File: tb/tb_pixel_select.sv
module tb_pixel_select;

    localparam int STRIDE   = 16;
    localparam int MAX_ROWS = 8;
    localparam int WCFG_W   = $clog2(STRIDE + 1);
    localparam int HCFG_W   = $clog2(MAX_ROWS + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WCFG_W-1:0] cfg_width = '0;
    logic [HCFG_W-1:0] cfg_height = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_index = '0;
    logic [31:0]       in_direct = '0;
    logic [31:0]       in_ctrl = '0;
    logic              pal_rd_en;
    logic [7:0]        pal_addr;
    logic [23:0]       pal_rgb = '0;
    logic              out_valid;
    logic [23:0]       out_rgb;

    int checks = 0;
    int errors = 0;
    int bcol = 0;
    int brow = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pixel_select #(
        .STRIDE  (STRIDE),
        .MAX_ROWS(MAX_ROWS)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_width (cfg_width),
        .cfg_height(cfg_height),
        .in_valid  (in_valid),
        .in_index  (in_index),
        .in_direct (in_direct),
        .in_ctrl   (in_ctrl),
        .pal_rd_en (pal_rd_en),
        .pal_addr  (pal_addr),
        .pal_rgb   (pal_rgb),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );

    function automatic logic [23:0] pal_f(input logic [7:0] i);
        return {i ^ 8'hA5, i + 8'h11, {i[3:0], i[7:4]}};
    endfunction

    // palette table model: one cycle read latency
    always @(posedge clk) begin
        if (pal_rd_en) pal_rgb <= pal_f(pal_addr);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int w, input int h);
        rst = 1'b1;
        in_valid = 1'b0;
        cfg_width = WCFG_W'(w);
        cfg_height = HCFG_W'(h);
        @(posedge clk); #2;
        check(out_valid == 1'b0, "R1 valid during reset", 32'(out_valid), 0);
        @(posedge clk); #2;
        rst = 1'b0;
        bcol = 0;
        brow = 0;
        @(posedge clk); #2;
        check(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
    endtask

    // present one cycle of input, then check the output one edge later
    task automatic push(input bit v, input logic [7:0] idx, input logic [31:0] dw,
                        input logic [31:0] cw, input string req);
        bit          ev;
        logic [23:0] er;
        in_valid = v;
        in_index = idx;
        in_direct = dw;
        in_ctrl = cw;
        ev = v && (bcol < int'(cfg_width)) && (brow < int'(cfg_height));
        er = (cw[31:24] == 8'h03) ? {dw[7:0], dw[15:8], dw[23:16]} : pal_f(idx);
        if (v) begin
            check(pal_rd_en && pal_addr == idx, "R3 palette request", {23'd0, pal_rd_en, pal_addr},
                  {24'd1, idx});
            bcol++;
            if (bcol == STRIDE) begin
                bcol = 0;
                brow = (brow == MAX_ROWS - 1) ? 0 : brow + 1;
            end
        end
        @(posedge clk); #2;
        check(out_valid == ev, {req, " valid"}, 32'(out_valid), 32'(ev));
        if (ev) check(out_rgb == er, {req, " colour"}, 32'(out_rgb), 32'(er));
    endtask

    function automatic logic [31:0] dword(input int k);
        return {8'(k * 3 + 5), 8'(k * 29 + 2), 8'(k * 13 + 1), 8'(k * 7)};
    endfunction

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset, then the very first pixel is at column 0 row 0
        do_reset(1, 1);
        push(1'b1, 8'd9, dword(1), 32'h0500_0000, "R1 origin pixel");
        push(1'b1, 8'd10, dword(2), 32'h0300_0000, "R1 second column hidden");

        // R2/R3/R4/R6/R7: every tag value, junk in ignored fields, window 10x5
        do_reset(10, 5);
        for (int k = 0; k < 2 * STRIDE * MAX_ROWS; k++) begin
            push(1'b1, 8'(k), dword(k), {8'(k * 5 + 3), 24'(k * 977)}, "R2 R3 R4 R6 R7 sweep");
        end

        // R5: alternating direct/palette, back to back, full window, frame wrap
        do_reset(STRIDE, MAX_ROWS);
        for (int k = 0; k < STRIDE * MAX_ROWS + 20; k++) begin
            push(1'b1, 8'(255 - k), dword(k + 7),
                 {(k % 2 == 0) ? 8'h03 : ((k % 4 == 1) ? 8'h02 : 8'h83), 24'hFFFFFF},
                 "R5 alternating stream");
        end

        // R4: direct pixels whose index and top byte change must not differ
        do_reset(STRIDE, MAX_ROWS);
        for (int k = 0; k < 32; k++) begin
            push(1'b1, 8'(k * 11), {8'(k), 24'h123456}, {8'h03, 24'(k)}, "R4 ignored fields");
        end

        // R8: idle gaps, window 7x3, including a gap on a column wrap
        do_reset(7, 3);
        for (int k = 0; k < 200; k++) begin
            push((k % 4) != 3, 8'(k * 3), dword(k), {(k % 3 == 0) ? 8'h03 : 8'h00, 24'd0},
                 "R8 gapped stream");
        end

        // R7: zero height hides everything
        do_reset(STRIDE, 0);
        for (int k = 0; k < 40; k++) begin
            push(1'b1, 8'(k), dword(k), 32'h0300_0000, "R7 zero height");
        end

        // R1: reset mid-stream restarts at the origin
        do_reset(3, 2);
        for (int k = 0; k < 5; k++) push(1'b1, 8'(k), dword(k), 32'h0, "R1 pre-reset");
        do_reset(3, 2);
        for (int k = 0; k < 20; k++) push(1'b1, 8'(k), dword(k), 32'h0300_0000, "R1 restart");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule